// File: doc/BRIEF.md
# Rational Modulo-Accumulator Clock Synthesizer

This block produces a lower-frequency timing clock from a reference clock when the ratio between the two is an exact fraction INC/MOD. The main case is a 1.544 MHz line clock from a 10 MHz reference, where the ratio is 193/1250. On each enabled reference cycle, a phase accumulator adds INC and wraps at MOD. MOD does not need to be a power of two. Each wrap is one output event. Over a long run, the output frequency is exactly INC/MOD of the reference, with no residual error.

There are three outputs. The first is a single-cycle tick for each output period. The second is a square wave that toggles whenever a second accumulator wraps; that accumulator runs at half the modulus, which gives close to 50 % duty. The third is the accumulator phase, so a modulus-specific sine table outside the block can be addressed from it. Individual edges are quantised to the reference clock, so they carry up to half a reference period of jitter either way. The average frequency is still locked.

Top module: `rmod_clk_synth`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `phase_o` to 0 and `sq_o` to 0.
- R2: After n enabled edges since reset, `phase_o` equals (n*INC) mod MOD.
- R3: `tick_o` is high exactly when `en` is high and the next enabled edge makes the full accumulator wrap, i.e. floor((n+1)*INC/MOD) differs from floor(n*INC/MOD).
- R4: While `en` is low, `phase_o` and `sq_o` keep their values and `tick_o` stays low.
- R5: After n enabled edges since reset, `sq_o` equals floor(n*INC/(MOD/2)) mod 2, so it toggles on each wrap of the half-modulus accumulator.
- R6: Over any MOD consecutive enabled cycles that start from reset, `tick_o` is high in exactly INC of them.
- R7: Over any MOD/2 consecutive enabled cycles that start from reset, `sq_o` changes exactly INC times.
- R8: `phase_o` is always less than MOD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; state holds when low |
| tick_o | output | 1 | One-cycle output event per synthesized period |
| sq_o | output | 1 | Square-wave output, about 50 % duty |
| phase_o | output | $clog2(MOD) | Full-modulus accumulator phase |

## Verification
The bench builds two copies of the block side by side. The first uses the default 193/1250 ratio: three full moduli run under continuous enable to confirm the exact tick and toggle counts of the line-clock case. The second uses INC=3 and MOD=10. Its short period makes every phase value, the wrap at the exact modulus boundary and many complete periods reachable within a few hundred random cycles. Random enable gaps and mid-run resets are applied to both copies.

// File: rtl/rmod_pkg.sv
package rmod_pkg;

  typedef struct packed {
    logic        wrap;
    logic [31:0] nxt;
  } step_t;

  // One modulo step: add inc, subtract modulus when the sum reaches it.
  function automatic step_t mod_step(input int unsigned acc,
                                     input int unsigned inc,
                                     input int unsigned modulus);
    step_t r;
    int unsigned sum;
    sum = acc + inc;
    r.wrap = (sum >= modulus);
    r.nxt  = r.wrap ? (sum - modulus) : sum;
    return r;
  endfunction

endpackage

// File: rtl/rmod_accum.sv
module rmod_accum #(
  parameter int unsigned INC = 193,
  parameter int unsigned MOD = 1250,
  localparam int PW = $clog2(MOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] phase_o,
  output logic          wrap_o
);
  import rmod_pkg::*;

  logic [PW-1:0] acc;
  step_t         step;

  always_comb begin
    step   = mod_step(32'(acc), INC, MOD);
    wrap_o = step.wrap;
  end

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= PW'(step.nxt);
  end

  assign phase_o = acc;

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(acc) < MOD);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (32'(acc) == (32'($past(acc)) + INC) % MOD));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

endmodule

// File: rtl/rmod_clk_synth.sv
module rmod_clk_synth #(
  parameter int unsigned INC = 193,
  parameter int unsigned MOD = 1250,
  localparam int unsigned HALF = MOD / 2,
  localparam int PW  = $clog2(MOD),
  localparam int HPW = $clog2(HALF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          tick_o,
  output logic          sq_o,
  output logic [PW-1:0] phase_o
);

  logic           full_wrap;
  logic           half_wrap;
  logic [HPW-1:0] half_phase;
  logic           sq_q;

  rmod_accum #(.INC(INC), .MOD(MOD)) u_full (
    .clk(clk), .rst(rst), .en(en), .phase_o(phase_o), .wrap_o(full_wrap)
  );

  rmod_accum #(.INC(INC), .MOD(HALF)) u_half (
    .clk(clk), .rst(rst), .en(en), .phase_o(half_phase), .wrap_o(half_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)                    sq_q <= 1'b0;
    else if (en && half_wrap)   sq_q <= ~sq_q;
  end

  assign tick_o = full_wrap & en;
  assign sq_o   = sq_q;

  // R3
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick_o);

  // R5
  sq_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (en && half_wrap) |=> (sq_o != $past(sq_o)));

  // R4
  sq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sq_o));

  // R8
  half_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(half_phase) < HALF);

endmodule

// File: tb/rmod_clk_synth_bench.sv
module rmod_clk_synth_bench;
  localparam int unsigned AI = 193, AM = 1250;
  localparam int unsigned BI = 3,   BM = 10;

  logic clk = 0, rst = 1, en = 0;
  logic tick_a, sq_a, tick_b, sq_b;
  logic [$clog2(AM)-1:0] ph_a;
  logic [$clog2(BM)-1:0] ph_b;

  int tests = 0, fails = 0;
  longint n = 0;
  bit armed = 0, done = 0;
  int tick_cnt = 0, tog_cnt = 0, tog_cnt_b = 0;
  logic prev_sq_a = 0, prev_sq_b = 0;

  always #4 clk = ~clk;

  rmod_clk_synth #(.INC(AI), .MOD(AM)) u_rmod_clk_synth (
    .clk(clk), .rst(rst), .en(en), .tick_o(tick_a), .sq_o(sq_a), .phase_o(ph_a));
  rmod_clk_synth #(.INC(BI), .MOD(BM)) u_small (
    .clk(clk), .rst(rst), .en(en), .tick_o(tick_b), .sq_o(sq_b), .phase_o(ph_b));

  function automatic longint exp_phase(longint k, longint i, longint m);
    return (k * i) % m;
  endfunction
  function automatic bit exp_tick(longint k, longint i, longint m, bit e);
    return e && (((k + 1) * i) / m != (k * i) / m);
  endfunction
  function automatic bit exp_sq(longint k, longint i, longint m);
    return bit'(((k * i) / (m / 2)) % 2);
  endfunction

  task automatic chk(string req, longint act, longint expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic check_all();
    chk("R2 phase A", ph_a, exp_phase(n, AI, AM));
    chk("R2 phase B", ph_b, exp_phase(n, BI, BM));
    chk("R3 tick A", tick_a, exp_tick(n, AI, AM, en));
    chk("R3 tick B", tick_b, exp_tick(n, BI, BM, en));
    chk("R5 sq A", sq_a, exp_sq(n, AI, AM));
    chk("R5 sq B", sq_b, exp_sq(n, BI, BM));
    chk("R8 range B", (ph_b < BM), 1);
  endtask

  task automatic step(input logic r, input logic e);
    @(negedge clk);
    if (armed) check_all();
    tick_cnt  += tick_a;
    tog_cnt   += (sq_a != prev_sq_a);
    tog_cnt_b += (sq_b != prev_sq_b);
    prev_sq_a = sq_a;
    prev_sq_b = sq_b;
    rst = r;
    en  = e;
    if (r) n = 0;
    else if (e) n++;
  endtask

  initial begin
    int seed;
    seed = 1544;
    void'($urandom(seed));
    step(1, 0);
    step(1, 1);
    armed = 1;
    // R1: reset state
    @(negedge clk);
    chk("R1 reset phase", ph_a, 0);
    chk("R1 reset sq", sq_a, 0);
    chk("R1 reset small sq", sq_b, 0);
    // random stimulus with enable gaps and an occasional reset
    for (int i = 0; i < 4000; i++) begin
      int v;
      v = $urandom % 100;
      step(v == 0, v < 75);
    end
    // R4: hold with enable low
    step(0, 0);
    begin
      logic [$clog2(AM)-1:0] ph0;
      logic sq0;
      ph0 = ph_a; sq0 = sq_a;
      for (int i = 0; i < 20; i++) step(0, 0);
      @(negedge clk);
      chk("R4 hold phase", ph_a, ph0);
      chk("R4 hold sq", sq_a, sq0);
      chk("R4 tick low", tick_a, 0);
    end
    // R6/R7: exact counts over three full moduli from reset
    step(1, 0);
    step(0, 1);
    tick_cnt = 0; tog_cnt = 0; tog_cnt_b = 0;
    prev_sq_a = 0; prev_sq_b = 0;
    for (int i = 0; i < 3 * AM - 1; i++) step(0, 1);
    step(0, 0);
    chk("R6 tick count", tick_cnt, 3 * AI);
    chk("R7 toggle count", tog_cnt, 6 * AI);
    chk("R7 toggle count small", tog_cnt_b, 3 * AM / (BM / 2) * BI);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule